// File: doc/BRIEF.md
# I2C Slave-Address XOR Rewriter

This block sits between the master-side and slave-side halves of an I2C bus and changes the 7-bit slave address while it is on the wire. After a START it follows the address byte bit by bit. It drives each address bit toward the slave side as the master's SDA level XORed with the matching bit of a configured translation mask. The R/W bit and every later bit pass through untouched. A single physical slave can therefore answer at a different address on the master's bus.

Both SCL and SDA arrive already synchronised to the block clock. The block produces three outputs: the SDA level for the slave side, and two connect flags, one for the data path and one for the clock path. The rewrite bit in use changes a short, programmable delay after each SCL falling edge, so it only moves while SCL is low. A START or STOP that arrives inside the address byte is handled by fixed recovery rules, and translation is abandoned if SCL stops toggling. A bypass input turns translation off at once.

Top module: `adxor_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_out` is 1 and both `sda_conn` and `scl_conn` are 1.
- R2: Outside an address byte, `sda_out` equals the value `sda_in` had one clock earlier.
- R3: After a START (SDA falling while SCL is high), the k-th address bit sent (k = 0 is the address MSB) leaves as `sda_in XOR xlat[ADDR_W-1-k]`. Each rewrite bit takes effect ADV_NS after the SCL falling edge that opens its bit slot, and the first slot opens at the first SCL fall after the START.
- R4: The R/W bit and all bits after it leave unchanged. A later START begins a fresh rewrite of the next address.
- R5: A START inside the address byte while the active rewrite bit is 0 reaches the slave side unchanged. Until the next STOP, all bits pass unchanged and further STARTs start no rewrite.
- R6: A START inside the address byte while the active rewrite bit is 1 appears on the slave side as a STOP (`sda_out` rising while SCL is high). The rewrite bit stays applied until the next SCL fall, and after that bits pass unchanged. The next STOP returns the block to normal operation.
- R7: A STOP inside the address byte while the active rewrite bit is 0 passes through unchanged, both connect flags stay 1, and the block returns to idle.
- R8: A STOP inside the address byte while the active rewrite bit is 1 starts a forced sequence. On the edge that sees the STOP, `sda_out` goes to 0 and both connect flags go to 0. STOP_DLY cycles later `sda_out` goes to 1 with the flags still 0. One cycle after that, both flags return to 1.
- R9: If SCL holds either level for STUCK_US while an address byte is being rewritten, the block abandons the rewrite and `sda_out` follows `sda_in`.
- R10: While `pass_thru` is 1, `sda_out` equals `sda_in` from one cycle earlier, both connect flags are 1, and no rewrite is active. This takes effect on the first edge that sees `pass_thru` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Synchronised master-side SCL |
| sda_in | input | 1 | Synchronised master-side SDA |
| xlat | input | ADDR_W | Address rewrite mask, MSB applied first |
| pass_thru | input | 1 | 1 = no rewrite, both paths joined |
| sda_out | output | 1 | SDA level toward the slave side |
| sda_conn | output | 1 | 1 = slave data path joined to master |
| scl_conn | output | 1 | 1 = slave clock path joined; 0 = slave SCL released high |

## Verification
Every output is registered, so a change on `sda_in` or `pass_thru` shows up on the clock edge that first samples it. A new rewrite bit is applied ADV cycles after the SCL fall has been registered. The bench therefore waits 20 cycles into each SCL-low slot before it moves SDA, then posts the expected level for the next edge. The forced STOP is checked at its exact offsets of 0, STOP_DLY and STOP_DLY+1 edges after the STOP is seen. The stuck-clock abort is checked a safe margin after STUCK_US cycles, for SCL held low and for SCL held high.

// File: rtl/adxor_pkg.sv
package adxor_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // plain pass, waiting for START
    ST_ADDR,   // rewriting the address bits
    ST_DATA,   // R/W and later bits, unchanged
    ST_SKIP,   // mid-address START seen, pass until STOP
    ST_FORCE,  // slave isolated, SDA held low
    ST_FREL    // slave isolated, SDA released (STOP formed)
  } xl_state_e;
endpackage

// File: rtl/adxor_busmon.sv
module adxor_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_det,
  output logic stop_det,
  output logic scl_fall,
  output logic scl_edge
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign start_det = scl_in && scl_q && sda_q && !sda_in;
  assign stop_det  = scl_in && scl_q && !sda_q && sda_in;
  assign scl_fall  = scl_q && !scl_in;
  assign scl_edge  = scl_q ^ scl_in;
endmodule

// File: rtl/adxor_tick.sv
module adxor_tick #(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  output logic fire
);
  localparam int unsigned W = (N < 2) ? 1 : $clog2(N + 1);
  localparam logic [W-1:0] LOADV = W'(N);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt <= '0;
    else if (load)         cnt <= LOADV;
    else if (cnt != '0)    cnt <= cnt - ONE;
  end

  assign fire = (cnt == ONE) && !load && !clear;
endmodule

// File: rtl/adxor_engine.sv
module adxor_engine
  import adxor_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned ADV_NS   = 100,
  parameter int unsigned STUCK_US = 30000,
  parameter int unsigned STOP_DLY = 50,
  parameter int unsigned ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] xlat,
  input  logic              pass_thru,
  output logic              sda_out,
  output logic              sda_conn,
  output logic              scl_conn
);
  localparam int unsigned ADV_RAW   = (ADV_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned ADV_CYC   = (ADV_RAW < 1) ? 1 : ADV_RAW;
  localparam int unsigned STUCK_CYC = (STUCK_US * CLK_MHZ < 2) ? 2 : STUCK_US * CLK_MHZ;
  localparam int unsigned DLY_CYC   = (STOP_DLY < 1) ? 1 : STOP_DLY;
  localparam int unsigned POS_W     = $clog2(ADDR_W + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(ADDR_W);

  logic start_det, stop_det, scl_fall, scl_edge;
  logic adv_fire, stuck_fire, force_fire;
  logic force_go;

  xl_state_e         state, st_n;
  logic [POS_W-1:0]  pos, pos_n;
  logic              mask_r, mask_n;
  logic [ADDR_W-1:0] xl_shift;
  logic              sda_n;

  adxor_busmon u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det),
    .scl_fall(scl_fall), .scl_edge(scl_edge)
  );

  // delay from SCL fall to the next rewrite bit
  adxor_tick #(.N(ADV_CYC)) u_adv (
    .clk(clk), .rst(rst), .load(scl_fall), .clear(start_det), .fire(adv_fire)
  );

  // SCL inactivity watch, held loaded outside the address byte
  adxor_tick #(.N(STUCK_CYC)) u_stuck (
    .clk(clk), .rst(rst), .load(scl_edge || (state != ST_ADDR)),
    .clear(1'b0), .fire(stuck_fire)
  );

  assign force_go = (state == ST_ADDR) && stop_det && mask_r && !pass_thru;

  // hold time of the forced low level before releasing SDA
  adxor_tick #(.N(DLY_CYC)) u_force (
    .clk(clk), .rst(rst), .load(force_go), .clear(pass_thru), .fire(force_fire)
  );

  assign xl_shift = xlat << pos;

  always_comb begin
    st_n   = state;
    pos_n  = pos;
    mask_n = mask_r;
    unique case (state)
      ST_IDLE: begin
        if (start_det) begin
          st_n   = ST_ADDR;
          pos_n  = '0;
          mask_n = 1'b0;
        end
      end
      ST_ADDR: begin
        if (stop_det) begin
          st_n   = mask_r ? ST_FORCE : ST_IDLE;
          mask_n = 1'b0;
        end else if (start_det) begin
          st_n   = ST_SKIP;
        end else if (stuck_fire) begin
          st_n   = ST_IDLE;
          mask_n = 1'b0;
        end else if (adv_fire) begin
          if (pos == POS_LAST) begin
            st_n   = ST_DATA;
            mask_n = 1'b0;
          end else begin
            pos_n  = pos + POS_W'(1);
            mask_n = xl_shift[ADDR_W-1];
          end
        end
      end
      ST_DATA: begin
        if (stop_det) begin
          st_n = ST_IDLE;
        end else if (start_det) begin
          st_n   = ST_ADDR;
          pos_n  = '0;
          mask_n = 1'b0;
        end
      end
      ST_SKIP: begin
        if (stop_det) begin
          st_n   = ST_IDLE;
          mask_n = 1'b0;
        end else if (scl_fall) begin
          mask_n = 1'b0;
        end
      end
      ST_FORCE: begin
        if (force_fire) st_n = ST_FREL;
      end
      ST_FREL: begin
        st_n = ST_IDLE;
      end
      default: begin
        st_n   = ST_IDLE;
        mask_n = 1'b0;
      end
    endcase
    if (pass_thru) begin
      st_n   = ST_IDLE;
      pos_n  = '0;
      mask_n = 1'b0;
    end
  end

  always_comb begin
    if (st_n == ST_FORCE)      sda_n = 1'b0;
    else if (st_n == ST_FREL)  sda_n = 1'b1;
    else                       sda_n = sda_in ^ mask_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pos      <= '0;
      mask_r   <= 1'b0;
      sda_out  <= 1'b1;
      sda_conn <= 1'b1;
      scl_conn <= 1'b1;
    end else begin
      state    <= st_n;
      pos      <= pos_n;
      mask_r   <= mask_n;
      sda_out  <= sda_n;
      sda_conn <= !(st_n == ST_FORCE || st_n == ST_FREL);
      scl_conn <= !(st_n == ST_FORCE || st_n == ST_FREL);
    end
  end
endmodule

// File: rtl/adxor_engine_chk.sv
module adxor_engine_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_in,
  input logic pass_thru,
  input logic sda_out,
  input logic sda_conn,
  input logic scl_conn
);
  // R1: first cycle out of reset shows the idle levels
  a_r1_reset_levels: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sda_out && sda_conn && scl_conn));

  // R10: bypass joins both paths and copies SDA
  a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
    pass_thru |=> (sda_out == $past(sda_in)) && sda_conn && scl_conn);

  // R8: isolation always starts with SDA held low
  a_r8_isolate_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_conn) |-> !sda_out);

  // R8: isolation only follows a STOP, seen with SCL high
  a_r8_isolate_after_scl_high: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_conn) |-> $past(scl_in));

  // R8: rejoin without bypass only after SDA was released
  a_r8_rejoin_high: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_conn) && !$past(pass_thru)) |-> $past(sda_out));
endmodule

bind adxor_engine adxor_engine_chk u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
  .pass_thru(pass_thru), .sda_out(sda_out),
  .sda_conn(sda_conn), .scl_conn(scl_conn)
);

// File: tb/sim_adxor_engine.sv
`timescale 1ns/1ps
module sim_adxor_engine;
  localparam int STOP_DLY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic pass_thru = 1'b0;
  logic [6:0] xlat = 7'h53;
  logic sda_out, sda_conn, scl_conn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  s;
    logic  dc;
    logic  cc;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  adxor_engine #(.CLK_MHZ(100), .ADV_NS(100), .STUCK_US(5),
                 .STOP_DLY(STOP_DLY), .ADDR_W(7)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .xlat(xlat),
    .pass_thru(pass_thru), .sda_out(sda_out), .sda_conn(sda_conn),
    .scl_conn(scl_conn)
  );

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (sda_out !== e.s || sda_conn !== e.dc || scl_conn !== e.cc) begin
        errors++;
        $display("FAIL %s: got sda=%b dconn=%b cconn=%b, want sda=%b dconn=%b cconn=%b",
                 e.tag, sda_out, sda_conn, scl_conn, e.s, e.dc, e.cc);
      end
    end
  end

  // result of the edge j cycles after the last drive
  task automatic post(input int j, input logic s, input logic dc, input logic cc,
                      input string tag);
    repeat (j) @(negedge clk);
    @(posedge clk);
    sb.push_back('{s: s, dc: dc, cc: cc, tag: tag});
  endtask

  task automatic send_bit(input logic b, input logic e, input string tag);
    @(negedge clk) scl = 1'b0;
    repeat (20) @(negedge clk);
    sda = b;
    post(1, e, 1'b1, 1'b1, tag);
    repeat (3) @(negedge clk);
    scl = 1'b1;
    post(2, e, 1'b1, 1'b1, tag);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start(input string tag);
    @(negedge clk) scl = 1'b0;
    repeat (5) @(negedge clk);
    sda = 1'b1;
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    sda = 1'b0;
    post(1, 1'b0, 1'b1, 1'b1, tag);
    repeat (5) @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk) scl = 1'b0;
    repeat (20) @(negedge clk);
    sda = 1'b0;
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    sda = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, input logic [6:0] x,
                           input string tag);
    for (int i = 6; i >= 0; i--) send_bit(a[i], a[i] ^ x[i], tag);
    send_bit(rw, rw, "R4 rw bit");
  endtask

  // open a slot in the address byte and leave SCL low
  task automatic open_slot();
    @(negedge clk) scl = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    post(0, 1'b1, 1'b1, 1'b1, "R1 in reset");
    @(negedge clk) rst = 1'b0;
    post(0, 1'b1, 1'b1, 1'b1, "R1 after reset");

    // R2: idle copy
    @(negedge clk) scl = 1'b0;
    repeat (3) @(negedge clk);
    sda = 1'b0;
    post(0, 1'b0, 1'b1, 1'b1, "R2 idle low");
    @(negedge clk) sda = 1'b1;
    post(0, 1'b1, 1'b1, 1'b1, "R2 idle high");
    @(negedge clk) scl = 1'b1;
    repeat (5) @(negedge clk);

    // R3/R4: pattern 1
    xlat = 7'h53;
    do_start("R3 start");
    send_addr(7'h50, 1'b1, 7'h53, "R3 addr 0x50");
    for (int i = 7; i >= 0; i--) send_bit(i[0], i[0], "R4 data");
    do_stop();

    // R3/R4: pattern 2 with repeated START
    xlat = 7'h2C;
    do_start("R3 start");
    send_addr(7'h3B, 1'b0, 7'h2C, "R3 addr 0x3B");
    do_start("R4 repeated start");
    send_addr(7'h3B, 1'b1, 7'h2C, "R4 re-translated addr");
    do_stop();

    // R6: START in address byte with rewrite bit 1
    xlat = 7'h53;
    do_start("R6 start");
    open_slot();
    sda = 1'b1;
    post(1, 1'b0, 1'b1, 1'b1, "R6 bit before start");
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    sda = 1'b0;
    post(1, 1'b1, 1'b1, 1'b1, "R6 start shown as stop");
    repeat (5) @(negedge clk);
    send_bit(1'b1, 1'b1, "R6 later bit unchanged");
    send_bit(1'b0, 1'b0, "R6 later bit unchanged");
    do_stop();
    do_start("R6 start after stop");
    send_addr(7'h11, 1'b0, 7'h53, "R6 normal after stop");
    do_stop();

    // R5: START in address byte with rewrite bit 0
    do_start("R5 start");
    send_bit(1'b1, 1'b0, "R5 first bit");
    open_slot();
    sda = 1'b1;
    post(1, 1'b1, 1'b1, 1'b1, "R5 bit before start");
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    sda = 1'b0;
    post(1, 1'b0, 1'b1, 1'b1, "R5 start passes");
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1, "R5 bits unchanged");
    do_start("R5 second start");
    send_bit(1'b1, 1'b1, "R5 no rewrite after start");
    do_stop();

    // R7: STOP in address byte with rewrite bit 0
    do_start("R7 start");
    send_bit(1'b1, 1'b0, "R7 first bit");
    open_slot();
    sda = 1'b0;
    post(1, 1'b0, 1'b1, 1'b1, "R7 bit before stop");
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    sda = 1'b1;
    post(0, 1'b1, 1'b1, 1'b1, "R7 stop passes");
    post(10, 1'b1, 1'b1, 1'b1, "R7 stays joined");
    repeat (3) @(negedge clk);
    send_bit(1'b0, 1'b0, "R7 idle after stop");

    // R8: STOP in address byte with rewrite bit 1
    do_start("R8 start");
    open_slot();
    sda = 1'b0;
    post(1, 1'b1, 1'b1, 1'b1, "R8 bit before stop");
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    sda = 1'b1;
    post(0, 1'b0, 1'b0, 1'b0, "R8 isolate low");
    post(STOP_DLY - 1, 1'b0, 1'b0, 1'b0, "R8 still low");
    post(1, 1'b1, 1'b0, 1'b0, "R8 release high");
    post(1, 1'b1, 1'b1, 1'b1, "R8 rejoin");
    repeat (3) @(negedge clk);
    do_start("R8 start after recovery");
    send_addr(7'h2A, 1'b0, 7'h53, "R8 normal after recovery");
    do_stop();

    // R9: SCL stuck low
    do_start("R9 start");
    open_slot();
    sda = 1'b1;
    post(1, 1'b0, 1'b1, 1'b1, "R9 rewritten before stall");
    post(530, 1'b1, 1'b1, 1'b1, "R9 stuck low abort");
    do_stop();

    // R9: SCL stuck high
    do_start("R9 start");
    send_bit(1'b1, 1'b0, "R9 rewritten before stall");
    post(520, 1'b1, 1'b1, 1'b1, "R9 stuck high abort");
    do_stop();

    // R10: bypass from idle
    @(negedge clk) pass_thru = 1'b1;
    do_start("R10 start");
    for (int i = 6; i >= 0; i--) send_bit(i[0], i[0], "R10 bypass bits");
    do_stop();

    // R10: bypass asserted mid-address
    @(negedge clk) pass_thru = 1'b0;
    do_start("R10 start");
    open_slot();
    sda = 1'b1;
    post(1, 1'b0, 1'b1, 1'b1, "R10 rewritten before bypass");
    repeat (3) @(negedge clk);
    pass_thru = 1'b1;
    post(0, 1'b1, 1'b1, 1'b1, "R10 bypass at once");
    do_stop();
    @(negedge clk) pass_thru = 1'b0;

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got run still active, want finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule